// File: doc/BRIEF.md
# Weighted Task Slot Arbiter

This block is the lower level of a two-level shared bus arbiter. The upper level picks a class of tasks and opens a window of a given number of task slots for it. For every slot in that window, this block picks at most one task of that class. It follows a weighted round-robin schedule that is built from per-task weights. A task whose turn arrives without a pending request is skipped, and the slot goes to the next eligible task in the scan.

Each class keeps its own slot index and its own set of sticky per-task flags. A window for one class therefore resumes exactly where that class stopped, even when windows of other classes run in between. A hyperperiod pulse clears the progress of every class. Each task slot lasts a fixed number of clock cycles, which leaves room for one complete, non-preempted access. The grant is registered and held for the whole slot. A done pulse marks the final cycle of the window.

Top module: `slot_task_arbiter`

## Requirements
- R1: `task_gnt` is zero or one-hot. A set bit names a task of the active class whose request bit (`task_req` bit c*N_TASK+j for class c, task j) was high at the clock edge that starts the slot.
- R2: An accepted window of size Z supplies exactly Z back-to-back slots of SLOT_CYC cycles each. The first slot starts at the edge that samples `win_start`. The grant is loaded at each slot's first edge and held until the slot ends.
- R3: At each slot start, tasks 0 to N_TASK-1 are scanned in index order. The class hyperperiod CH is the sum of the class weights. A task's flag is cleared when the running class index modulo CH/weight equals 0. The first task found with a clear flag has its flag set, and the index is incremented and wraps to 0 at CH. That task is granted if it requests. Weight fields are WT_W bits wide at bit offset (c*N_TASK+j)*WT_W of `task_wt`.
- R4: A task whose flag is clear but which has no request loses that turn: its flag is set, the index advances and the scan moves on to the next task in the same slot.
- R5: If every task requests, each task receives as many slots as its weight over CH consecutive slots. Weights 3,2,1 produce the order task0, task1, task0, task1, task0, task2.
- R6: A slot in which no task is taken with a request passes idle, with `task_gnt` zero for the whole slot.
- R7: A task of weight 0 is never granted and adds nothing to CH.
- R8: The index and flags of each class are kept separately, so windows of other classes do not disturb them.
- R9: `hp_start` clears the index and flags of every class. A slot that starts in the same cycle scans from the cleared state.
- R10: `win_done` is high for exactly one cycle, the last cycle of the last slot. `task_gnt` is zero in the next cycle.
- R11: `win_start` is ignored while a window is running, when `win_size` is 0, or when `win_class` is N_CLASS or higher.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_start | input | 1 | Hyperperiod start pulse; clears all class progress |
| win_start | input | 1 | Opens a window for `win_class` |
| win_class | input | CLS_W | Class granted by the upper level |
| win_size | input | Z_W | Number of task slots in the window |
| task_req | input | N_CLASS*N_TASK | Pending request per task, bit c*N_TASK+j |
| task_wt | input | N_CLASS*N_TASK*WT_W | Per-task weights from configuration |
| task_gnt | output | N_TASK | Registered one-hot task grant for the current slot |
| win_done | output | 1 | One-cycle pulse in the last cycle of the window |

## Verification
Some properties are checked by assertions on every cycle: the grant is zero or one-hot, it goes only to a task that was requesting at the slot edge, it stays stable within a slot, it is zero outside a window, a window ends right after done, and the hyperperiod clear reaches the class registers. The schedule order is only shown by the bench's directed scenarios. These cover the order produced by the weights, skipping of idle tasks, idle slots, class state kept across interleaved windows, restart after a hyperperiod pulse, and rejected window starts. Each scenario is compared against a model written from the scan rule.

// File: rtl/sta_pkg.sv
package sta_pkg;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_e;

    // Index width able to hold the largest class hyperperiod.
    function automatic int unsigned idx_width(int unsigned n_task, int unsigned wt_w);
        return $clog2(n_task * ((1 << wt_w) - 1) + 1);
    endfunction

    function automatic int unsigned cnt_width(int unsigned slot_cyc);
        return (slot_cyc > 1) ? $clog2(slot_cyc) : 1;
    endfunction

endpackage

// File: rtl/sta_task_scan.sv
module sta_task_scan #(
    parameter int unsigned N_TASK = 4,
    parameter int unsigned WT_W   = 3,
    parameter int unsigned IDX_W  = 5
) (
    input  logic [N_TASK*WT_W-1:0] wt,
    input  logic [N_TASK-1:0]      req,
    input  logic [N_TASK-1:0]      flg_in,
    input  logic [IDX_W-1:0]       idx_in,
    output logic [N_TASK-1:0]      gnt,
    output logic [N_TASK-1:0]      flg_out,
    output logic [IDX_W-1:0]       idx_out
);

    logic [IDX_W-1:0] ch;

    always_comb begin
        ch = '0;
        for (int j = 0; j < N_TASK; j++) begin
            ch = ch + IDX_W'(wt[j*WT_W +: WT_W]);
        end
    end

    // Sequential scan in index order, unrolled into one combinational pass.
    always_comb begin
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] per;
        logic [WT_W-1:0]  w;
        logic             taken;
        idx     = idx_in;
        per     = '0;
        w       = '0;
        taken   = 1'b0;
        gnt     = '0;
        flg_out = flg_in;
        for (int j = 0; j < N_TASK; j++) begin
            w = wt[j*WT_W +: WT_W];
            if (w != '0) begin
                per = ch / IDX_W'(w);
                if ((idx % per) == '0) begin
                    flg_out[j] = 1'b0;
                end
                if (!flg_out[j] && !taken) begin
                    flg_out[j] = 1'b1;
                    idx = (idx == ch - 1'b1) ? '0 : idx + 1'b1;
                    if (req[j]) begin
                        gnt[j] = 1'b1;
                        taken  = 1'b1;
                    end
                end
            end
        end
        idx_out = idx;
    end

endmodule

// File: rtl/sta_class_bank.sv
module sta_class_bank #(
    parameter int unsigned N_CLASS = 3,
    parameter int unsigned N_TASK  = 4,
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned CLS_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hp_clr,
    input  logic              upd,
    input  logic [CLS_W-1:0]  cls,
    input  logic              cls_ok,
    input  logic [IDX_W-1:0]  idx_nxt,
    input  logic [N_TASK-1:0] flg_nxt,
    output logic [IDX_W-1:0]  idx_rd,
    output logic [N_TASK-1:0] flg_rd
);

    logic [IDX_W-1:0]  idx_q [N_CLASS];
    logic [N_TASK-1:0] flg_q [N_CLASS];

    always_ff @(posedge clk) begin
        for (int c = 0; c < N_CLASS; c++) begin
            if (rst) begin
                idx_q[c] <= '0;
                flg_q[c] <= '0;
            end else if (upd && cls_ok && (32'(cls) == c)) begin
                idx_q[c] <= idx_nxt;
                flg_q[c] <= flg_nxt;
            end else if (hp_clr) begin
                idx_q[c] <= '0;
                flg_q[c] <= '0;
            end
        end
    end

    // A clear in the same cycle is forwarded to the scan.
    always_comb begin
        idx_rd = '0;
        flg_rd = '0;
        if (cls_ok && !hp_clr) begin
            idx_rd = idx_q[cls];
            flg_rd = flg_q[cls];
        end
    end

    // R9: a clear without a concurrent update empties the first class
    a_r9_hp_clears: assert property (@(posedge clk) disable iff (rst)
        (hp_clr && !upd) |=> (idx_q[0] == '0 && flg_q[0] == '0));

endmodule

// File: rtl/sta_slot_timer.sv
module sta_slot_timer
    import sta_pkg::*;
#(
    parameter int unsigned Z_W      = 4,
    parameter int unsigned SLOT_CYC = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [Z_W-1:0] size,
    output logic           busy,
    output logic           fire,
    output logic           done
);

    localparam int unsigned CNT_W = cnt_width(SLOT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYC - 1);

    win_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [Z_W-1:0]   left_q;
    logic             slot_end;

    assign busy     = (state_q == WIN_RUN);
    assign slot_end = busy && (cnt_q == LAST);
    assign done     = slot_end && (left_q == Z_W'(1));
    assign fire     = (start && !busy) || (slot_end && left_q > Z_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_IDLE;
            cnt_q   <= '0;
            left_q  <= '0;
        end else if (!busy) begin
            if (start) begin
                state_q <= WIN_RUN;
                cnt_q   <= '0;
                left_q  <= size;
            end
        end else if (slot_end) begin
            cnt_q <= '0;
            if (left_q == Z_W'(1)) begin
                state_q <= WIN_IDLE;
            end
            left_q <= left_q - 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: a running window never has zero slots left
    a_r2_left_nonzero: assert property (@(posedge clk) disable iff (rst)
        busy |-> (left_q != '0));
    // R2: the window cannot end in the middle of a slot
    a_r2_no_early_end: assert property (@(posedge clk) disable iff (rst)
        (busy && !slot_end) |=> busy);
    // R10: the window closes right after done
    a_r10_done_closes: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/slot_task_arbiter.sv
module slot_task_arbiter
    import sta_pkg::*;
#(
    parameter int unsigned N_CLASS  = 3,
    parameter int unsigned N_TASK   = 4,
    parameter int unsigned WT_W     = 3,
    parameter int unsigned Z_W      = 4,
    parameter int unsigned SLOT_CYC = 4,
    localparam int unsigned CLS_W   = (N_CLASS > 1) ? $clog2(N_CLASS) : 1,
    localparam int unsigned IDX_W   = idx_width(N_TASK, WT_W)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hp_start,
    input  logic                        win_start,
    input  logic [CLS_W-1:0]            win_class,
    input  logic [Z_W-1:0]              win_size,
    input  logic [N_CLASS*N_TASK-1:0]   task_req,
    input  logic [N_CLASS*N_TASK*WT_W-1:0] task_wt,
    output logic [N_TASK-1:0]           task_gnt,
    output logic                        win_done
);

    logic [N_TASK-1:0]      req_cls [N_CLASS];
    logic [N_TASK*WT_W-1:0] wt_cls  [N_CLASS];

    for (genvar c = 0; c < N_CLASS; c++) begin : g_cls
        assign req_cls[c] = task_req[c*N_TASK +: N_TASK];
        assign wt_cls[c]  = task_wt[c*N_TASK*WT_W +: N_TASK*WT_W];
    end

    logic              busy, fire, accept, cls_ok;
    logic [CLS_W-1:0]  cls_q, cls_sel;
    logic [N_TASK-1:0] req_sel, gnt_nxt, gnt_q, flg_rd, flg_nxt;
    logic [N_TASK*WT_W-1:0] wt_sel;
    logic [IDX_W-1:0]  idx_rd, idx_nxt;

    assign cls_sel = busy ? cls_q : win_class;
    assign cls_ok  = (32'(cls_sel) < N_CLASS);
    assign accept  = win_start && (win_size != '0) && (32'(win_class) < N_CLASS);
    assign req_sel = cls_ok ? req_cls[cls_sel] : '0;
    assign wt_sel  = cls_ok ? wt_cls[cls_sel]  : '0;

    sta_slot_timer #(.Z_W(Z_W), .SLOT_CYC(SLOT_CYC)) timer_i (
        .clk(clk), .rst(rst), .start(accept), .size(win_size),
        .busy(busy), .fire(fire), .done(win_done)
    );

    sta_class_bank #(.N_CLASS(N_CLASS), .N_TASK(N_TASK), .IDX_W(IDX_W), .CLS_W(CLS_W)) bank_i (
        .clk(clk), .rst(rst), .hp_clr(hp_start), .upd(fire),
        .cls(cls_sel), .cls_ok(cls_ok),
        .idx_nxt(idx_nxt), .flg_nxt(flg_nxt),
        .idx_rd(idx_rd), .flg_rd(flg_rd)
    );

    sta_task_scan #(.N_TASK(N_TASK), .WT_W(WT_W), .IDX_W(IDX_W)) scan_i (
        .wt(wt_sel), .req(req_sel), .flg_in(flg_rd), .idx_in(idx_rd),
        .gnt(gnt_nxt), .flg_out(flg_nxt), .idx_out(idx_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= '0;
            gnt_q <= '0;
        end else begin
            if (accept && !busy) begin
                cls_q <= win_class;
            end
            if (fire) begin
                gnt_q <= gnt_nxt;
            end else if (win_done) begin
                gnt_q <= '0;
            end
        end
    end

    assign task_gnt = gnt_q;

    // R1: at most one task granted
    a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(task_gnt));
    // R1: a granted task was requesting at the slot edge
    a_r1_req_held: assert property (@(posedge clk) disable iff (rst)
        fire |=> ((task_gnt & ~$past(req_sel)) == '0));
    // R2: the grant does not move inside a slot
    a_r2_gnt_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire && !win_done) |=> $stable(task_gnt));
    // R10: no grant outside a window
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (task_gnt == '0));

endmodule

// File: tb/slot_task_arbiter_tb.sv
`timescale 1ns/1ps
module slot_task_arbiter_tb_top;

    localparam int N_CLASS  = 3;
    localparam int N_TASK   = 4;
    localparam int WT_W     = 3;
    localparam int Z_W      = 4;
    localparam int SLOT_CYC = 4;
    localparam int CLS_W    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hp_start = 1'b0;
    logic win_start = 1'b0;
    logic [CLS_W-1:0] win_class = '0;
    logic [Z_W-1:0] win_size = '0;
    logic [N_CLASS*N_TASK-1:0] task_req = '0;
    logic [N_CLASS*N_TASK*WT_W-1:0] task_wt = '0;
    logic [N_TASK-1:0] task_gnt;
    logic win_done;

    always #2 clk = ~clk;

    slot_task_arbiter #(.N_CLASS(N_CLASS), .N_TASK(N_TASK), .WT_W(WT_W),
                        .Z_W(Z_W), .SLOT_CYC(SLOT_CYC)) dut_i (
        .clk(clk), .rst(rst), .hp_start(hp_start), .win_start(win_start),
        .win_class(win_class), .win_size(win_size), .task_req(task_req),
        .task_wt(task_wt), .task_gnt(task_gnt), .win_done(win_done)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    int wts [N_CLASS][N_TASK];
    int m_idx [N_CLASS];
    bit m_flg [N_CLASS][N_TASK];
    logic [N_TASK-1:0] rec [16];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < N_CLASS; c++) begin
            m_idx[c] = 0;
            for (int j = 0; j < N_TASK; j++) m_flg[c][j] = 1'b0;
        end
    endtask

    // Scan rule of R3/R4 applied to one slot of class c.
    task automatic model_slot(input int c, output logic [N_TASK-1:0] g);
        int ch;
        int idx;
        bit taken;
        ch = 0;
        for (int j = 0; j < N_TASK; j++) ch += wts[c][j];
        idx = m_idx[c];
        taken = 1'b0;
        g = '0;
        for (int j = 0; j < N_TASK; j++) begin
            if (wts[c][j] != 0) begin
                if (idx % (ch / wts[c][j]) == 0) m_flg[c][j] = 1'b0;
                if (!m_flg[c][j] && !taken) begin
                    m_flg[c][j] = 1'b1;
                    idx = (idx + 1 == ch) ? 0 : idx + 1;
                    if (task_req[c*N_TASK + j]) begin
                        g[j] = 1'b1;
                        taken = 1'b1;
                    end
                end
            end
        end
        m_idx[c] = idx;
    endtask

    task automatic set_req(input int c, input logic [N_TASK-1:0] bits);
        task_req[c*N_TASK +: N_TASK] = bits;
    endtask

    task automatic run_window(input int c, input int z, input bit with_hp,
                              input bit poke, input string tag);
        logic [N_TASK-1:0] exp_g;
        @(negedge clk);
        win_start = 1'b1;
        win_class = CLS_W'(c);
        win_size  = Z_W'(z);
        hp_start  = with_hp;
        if (with_hp) model_clear();
        for (int k = 0; k < z; k++) begin
            model_slot(c, exp_g);
            for (int s = 0; s < SLOT_CYC; s++) begin
                @(posedge clk);
                @(negedge clk);
                if (k == 0 && s == 0) begin
                    win_start = 1'b0;
                    hp_start  = 1'b0;
                end
                if (poke && k == 0 && s == 1) begin
                    win_start = 1'b1;
                    win_class = CLS_W'((c + 1) % N_CLASS);
                    win_size  = Z_W'(1);
                end
                if (poke && k == 0 && s == 2) win_start = 1'b0;
                if (s == 0) begin
                    rec[k] = task_gnt;
                    chk(task_gnt == exp_g, {tag, " R3 grant at slot start"}, task_gnt, exp_g);
                    chk(task_gnt[N_TASK-1] == 1'b0 || wts[c][N_TASK-1] != 0,
                        "R7 weight-0 task granted", task_gnt, exp_g);
                end
                if (s == SLOT_CYC - 1) begin
                    chk(task_gnt == exp_g, {tag, " R2 grant held to slot end"}, task_gnt, exp_g);
                    chk(win_done == (k == z - 1), {tag, " R10 done timing"}, win_done, (k == z - 1));
                end else begin
                    chk(win_done == 1'b0, {tag, " R10 done early"}, win_done, 0);
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(task_gnt == '0, {tag, " R10 grant drops after window"}, task_gnt, 0);
        chk(win_done == 1'b0, {tag, " R10 done single cycle"}, win_done, 0);
    endtask

    task automatic t_reset();
        chk(task_gnt == '0, "R10 reset grant", task_gnt, 0);
        chk(win_done == 1'b0, "R10 reset done", win_done, 0);
    endtask

    task automatic t_example();
        logic [N_TASK-1:0] exp_seq [6];
        exp_seq = '{4'b0001, 4'b0010, 4'b0001, 4'b0010, 4'b0001, 4'b0100};
        set_req(0, 4'b1111);
        run_window(0, 6, 1'b1, 1'b0, "example");
        for (int k = 0; k < 6; k++)
            chk(rec[k] == exp_seq[k], "R5 weighted order 3,2,1", rec[k], exp_seq[k]);
    endtask

    task automatic t_pass_over();
        set_req(1, 4'b1010);
        run_window(1, 4, 1'b0, 1'b0, "passover");
        chk(rec[0] == 4'b0010, "R4 task0 skipped for task1", rec[0], 4'b0010);
        chk(rec[1] == 4'b1000, "R4 task2 skipped for task3", rec[1], 4'b1000);
    endtask

    task automatic t_idle();
        set_req(2, 4'b0000);
        run_window(2, 3, 1'b0, 1'b0, "idle");
        for (int k = 0; k < 3; k++)
            chk(rec[k] == '0, "R6 idle slot", rec[k], 0);
    endtask

    task automatic t_switch();
        set_req(2, 4'b1111);
        run_window(0, 2, 1'b0, 1'b0, "R8 switch a");
        run_window(2, 3, 1'b0, 1'b0, "R8 switch b");
        run_window(0, 4, 1'b0, 1'b0, "R8 switch c");
    endtask

    task automatic t_hp();
        run_window(0, 3, 1'b1, 1'b0, "R9 hp restart");
        chk(rec[0] == 4'b0001, "R9 first slot after clear", rec[0], 4'b0001);
        chk(rec[1] == 4'b0010, "R9 second slot after clear", rec[1], 4'b0010);
    endtask

    task automatic t_ignore();
        @(negedge clk);
        win_start = 1'b1; win_class = 2'd0; win_size = '0;
        @(negedge clk);
        win_class = 2'd3; win_size = Z_W'(2);
        @(negedge clk);
        win_start = 1'b0;
        for (int s = 0; s < 2 * SLOT_CYC; s++) begin
            @(negedge clk);
            chk(task_gnt == '0 && win_done == 1'b0, "R11 rejected start", task_gnt, 0);
        end
        run_window(0, 3, 1'b0, 1'b1, "R11 start while busy");
        run_window(1, 2, 1'b0, 1'b0, "R11 class1 untouched");
    endtask

    initial begin
        wts[0] = '{3, 2, 1, 0};
        wts[1] = '{1, 1, 1, 1};
        wts[2] = '{4, 2, 2, 0};
        for (int c = 0; c < N_CLASS; c++)
            for (int j = 0; j < N_TASK; j++)
                task_wt[(c*N_TASK + j)*WT_W +: WT_W] = WT_W'(wts[c][j]);
        model_clear();
        task_req[N_TASK-1] = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_example();
        t_pass_over();
        t_idle();
        t_switch();
        t_hp();
        t_ignore();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule